// File: doc/BRIEF.md
# Partitioned Associative Memory Array

This block is a content addressable memory. It holds a parameterised number of 64-bit entries, and each entry carries a two-bit type tag. A global split input divides every entry into two fields on 16-bit segment boundaries. The compared field always starts at segment 0. The rest of the entry is plain stored data that never takes part in a match.

A compare checks a 64-bit key against every entry whose tag equals the selected type. The key can optionally be masked bit by bit. One clock later the block reports:

- a match flag and the lowest matching address;
- the lowest Empty address;
- a full flag.

Writes, tag-only updates and reads can be aimed at an absolute address, at the held match result, or at the lowest Empty entry. A read also returns the tag of the entry it read.

The block sits behind a command decoder, which owns the host bus and the configuration registers. The decoder drives the split, mask and enable inputs as static levels. It issues compare, write and read requests as single-cycle pulses.

Top module: `pam_array`

## Requirements
- R1: While reset is held, every tag becomes Empty and every data word becomes zero. On the first cycle after reset, match_flag and full_flag are 0 and free_addr is 0.
- R2: A compare request loads the result registers at the next rising edge. match_addr is then the lowest-numbered matching entry, or 0 when nothing matches.
- R3: Tags are encoded as Empty=2'b00, Valid=2'b01, Skip=2'b10 and RAM=2'b11. With cmp_auto=1 only Valid entries can match. With cmp_auto=0 only entries whose tag equals cmp_type can match.
- R4: Segment k is bits 16k+15:16k. Only segments 0 through split_sel take part in a compare. A difference in any higher segment does not prevent a match.
- R5: When mask_en=1, a 1 in cmp_mask makes that bit a don't-care. When mask_en=0, cmp_mask has no effect.
- R6: The compare result is held until the next compare request. A match_rst pulse without a compare clears the flag and sets match_addr to 0. A compare in the same cycle takes precedence over match_rst.
- R7: free_addr is the lowest address tagged Empty. The internal full condition holds when no entry is Empty, and free_addr is 0 in that case.
- R8: match_en=0 forces match_flag to 0 and full_en=0 forces full_flag to 0. Both enables act combinationally and leave the held state untouched.
- R9: wr_mode selects the write target: 0 is wr_addr, 1 is the held match address, 2 is free_addr, and 3 means no target. A write is ignored when mode 1 has no held match, when mode 2 finds the array full, and always in mode 3.
- R10: A write with wr_tag_only=1 updates only the tag and leaves the stored data unchanged.
- R11: rd_mode resolves a read target with the same rule as wr_mode. A resolved read gives rd_valid=1, the entry's data and its tag on rd_tag one cycle later. An unresolved read gives rd_valid=0 and leaves rd_tag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_sel | input | 2 | Highest compared segment (0..3) |
| mask_en | input | 1 | Enable bitwise compare mask |
| cmp_mask | input | 64 | Compare mask, 1 = don't-care |
| cmp_req | input | 1 | Compare request pulse |
| cmp_auto | input | 1 | 1 = compare against Valid entries only |
| cmp_type | input | 2 | Tag selected when cmp_auto=0 |
| cmp_key | input | 64 | Comparand |
| match_rst | input | 1 | Clear the held match result |
| match_en | input | 1 | Match flag enable |
| full_en | input | 1 | Full flag enable |
| wr_req | input | 1 | Write request pulse |
| wr_mode | input | 2 | Write target mode |
| wr_tag_only | input | 1 | Update the tag only |
| wr_addr | input | $clog2(ENTRIES) | Absolute write address |
| wr_data | input | 64 | Write data |
| wr_tag | input | 2 | Tag written with the entry |
| rd_req | input | 1 | Read request pulse |
| rd_mode | input | 2 | Read target mode |
| rd_addr | input | $clog2(ENTRIES) | Absolute read address |
| match_flag | output | 1 | Gated held match flag |
| match_addr | output | $clog2(ENTRIES) | Held highest-priority match address |
| free_addr | output | $clog2(ENTRIES) | Lowest Empty address |
| full_flag | output | 1 | Gated full flag |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| rd_tag | output | 2 | Tag of the last entry read |

## Verification
The compare is tried with five kinds of key.

- **Exact key held twice.** The same key is stored at two addresses, which separates lowest-address priority from any other pick.
- **Skip-tagged key.** The key matches an entry retagged Skip, so an automatic compare must miss it while an explicit Skip compare must find it.
- **Key differing in the top segment.** This is tried with the split at 3 and at 2, which tells a real field restriction from a full-width compare.
- **Key differing in one low bit.** This is tried with the mask on and off, which tells real masking from a mask that is ignored.
- **Key with no match.**

Write and read targeting is tried with a held hit, a cleared hit, free space and a full array. The two unresolved cases, a cleared hit and a full array, point at address 0. This shows that a dropped access really is dropped, rather than landing on the default address.

// File: rtl/pam_pkg.sv
package pam_pkg;

    localparam int WORD_W = 64;
    localparam int SEG_W  = 16;
    localparam int SEGS   = WORD_W / SEG_W;
    localparam int SPL_W  = $clog2(SEGS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SPL_W-1:0]  split_t;

    typedef enum logic [1:0] {
        TAG_EMPTY = 2'b00,
        TAG_VALID = 2'b01,
        TAG_SKIP  = 2'b10,
        TAG_RAM   = 2'b11
    } tag_e;

    typedef enum logic [1:0] {
        AM_ABS   = 2'd0,
        AM_MATCH = 2'd1,
        AM_FREE  = 2'd2,
        AM_NONE  = 2'd3
    } amode_e;

    typedef struct packed {
        word_t key;
        word_t care;
        tag_e  sel;
    } cmp_ctx_t;

    // Bits of the compared field for a given split setting.
    function automatic word_t field_bits(input split_t split);
        word_t f;
        f = '0;
        for (int s = 0; s < SEGS; s++) begin
            if (s <= int'(split)) f[s*SEG_W +: SEG_W] = '1;
        end
        return f;
    endfunction

    // Bits that must agree for a match: in the field and not masked.
    function automatic word_t care_bits(input split_t split, input logic use_mask,
                                        input word_t mask);
        word_t m;
        m = use_mask ? mask : '0;
        return field_bits(split) & ~m;
    endfunction

endpackage

// File: rtl/pam_lowest.sv
module pam_lowest #(
    parameter int N  = 16,
    parameter int AW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [AW-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = AW'(i);
        end
    end
endmodule

// File: rtl/pam_store.sv
module pam_store
    import pam_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          tag_only,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  tag_e          wtag,
    output word_t         data [N],
    output tag_e          tags [N]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                data[i] <= '0;
                tags[i] <= TAG_EMPTY;
            end
        end else if (we) begin
            tags[waddr] <= wtag;
            if (!tag_only) data[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/pam_match.sv
module pam_match
    import pam_pkg::*;
#(
    parameter int N = 16
) (
    input  cmp_ctx_t   ctx,
    input  word_t      data [N],
    input  tag_e       tags [N],
    output logic [N-1:0] hit,
    output logic [N-1:0] empty
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic diff;
        assign diff     = |((data[g] ^ ctx.key) & ctx.care);
        assign hit[g]   = (tags[g] == ctx.sel) && !diff;
        assign empty[g] = (tags[g] == TAG_EMPTY);
    end
endmodule

// File: rtl/pam_resolve.sv
module pam_resolve
    import pam_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic [1:0]    mode,
    input  logic [AW-1:0] abs_addr,
    input  logic          hit_ok,
    input  logic [AW-1:0] hit_addr,
    input  logic          free_ok,
    input  logic [AW-1:0] free_addr,
    output logic          ok,
    output logic [AW-1:0] addr
);
    always_comb begin
        ok   = 1'b0;
        addr = '0;
        unique case (amode_e'(mode))
            AM_ABS:   begin ok = 1'b1;    addr = abs_addr;  end
            AM_MATCH: begin ok = hit_ok;  addr = hit_addr;  end
            AM_FREE:  begin ok = free_ok; addr = free_addr; end
            default:  begin ok = 1'b0;    addr = '0;        end
        endcase
    end
endmodule

// File: rtl/pam_array.sv
module pam_array
    import pam_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int AW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    split_sel,
    input  logic          mask_en,
    input  logic [63:0]   cmp_mask,
    input  logic          cmp_req,
    input  logic          cmp_auto,
    input  logic [1:0]    cmp_type,
    input  logic [63:0]   cmp_key,
    input  logic          match_rst,
    input  logic          match_en,
    input  logic          full_en,
    input  logic          wr_req,
    input  logic [1:0]    wr_mode,
    input  logic          wr_tag_only,
    input  logic [AW-1:0] wr_addr,
    input  logic [63:0]   wr_data,
    input  logic [1:0]    wr_tag,
    input  logic          rd_req,
    input  logic [1:0]    rd_mode,
    input  logic [AW-1:0] rd_addr,
    output logic          match_flag,
    output logic [AW-1:0] match_addr,
    output logic [AW-1:0] free_addr,
    output logic          full_flag,
    output logic          rd_valid,
    output logic [63:0]   rd_data,
    output logic [1:0]    rd_tag
);
    word_t        data [ENTRIES];
    tag_e         tags [ENTRIES];
    cmp_ctx_t     ctx;
    logic [ENTRIES-1:0] hit_vec, empty_vec;
    logic         any_hit, any_free;
    logic [AW-1:0] hit_idx, free_idx;
    logic         hit_q;
    logic [AW-1:0] hit_addr_q;
    logic         wr_ok, rd_ok;
    logic [AW-1:0] wr_tgt, rd_tgt;
    logic         rd_valid_q;
    word_t        rd_data_q;
    tag_e         rd_tag_q;

    // Compare context: selected tag, key and care bits.
    always_comb begin
        ctx.key  = cmp_key;
        ctx.care = care_bits(split_t'(split_sel), mask_en, cmp_mask);
        ctx.sel  = cmp_auto ? TAG_VALID : tag_e'(cmp_type);
    end

    pam_match #(.N(ENTRIES)) u_match (
        .ctx   (ctx),
        .data  (data),
        .tags  (tags),
        .hit   (hit_vec),
        .empty (empty_vec)
    );

    pam_lowest #(.N(ENTRIES), .AW(AW)) u_hit_enc (
        .req   (hit_vec),
        .found (any_hit),
        .idx   (hit_idx)
    );

    pam_lowest #(.N(ENTRIES), .AW(AW)) u_free_enc (
        .req   (empty_vec),
        .found (any_free),
        .idx   (free_idx)
    );

    // Held compare result.
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q      <= 1'b0;
            hit_addr_q <= '0;
        end else if (cmp_req) begin
            hit_q      <= any_hit;
            hit_addr_q <= hit_idx;
        end else if (match_rst) begin
            hit_q      <= 1'b0;
            hit_addr_q <= '0;
        end
    end

    pam_resolve #(.AW(AW)) u_wr_res (
        .mode      (wr_mode),
        .abs_addr  (wr_addr),
        .hit_ok    (hit_q),
        .hit_addr  (hit_addr_q),
        .free_ok   (any_free),
        .free_addr (free_idx),
        .ok        (wr_ok),
        .addr      (wr_tgt)
    );

    pam_resolve #(.AW(AW)) u_rd_res (
        .mode      (rd_mode),
        .abs_addr  (rd_addr),
        .hit_ok    (hit_q),
        .hit_addr  (hit_addr_q),
        .free_ok   (any_free),
        .free_addr (free_idx),
        .ok        (rd_ok),
        .addr      (rd_tgt)
    );

    pam_store #(.N(ENTRIES), .AW(AW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (wr_req && wr_ok),
        .tag_only (wr_tag_only),
        .waddr    (wr_tgt),
        .wdata    (wr_data),
        .wtag     (tag_e'(wr_tag)),
        .data     (data),
        .tags     (tags)
    );

    // Registered read port.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
            rd_tag_q   <= TAG_EMPTY;
        end else begin
            rd_valid_q <= rd_req && rd_ok;
            if (rd_req && rd_ok) begin
                rd_data_q <= data[rd_tgt];
                rd_tag_q  <= tags[rd_tgt];
            end
        end
    end

    assign match_flag = hit_q && match_en;
    assign match_addr = hit_addr_q;
    assign free_addr  = free_idx;
    assign full_flag  = !any_free && full_en;
    assign rd_valid   = rd_valid_q;
    assign rd_data    = rd_data_q;
    assign rd_tag     = rd_tag_q;

endmodule

// File: rtl/pam_array_chk.sv
module pam_array_chk #(
    parameter int ENTRIES = 16,
    localparam int AW = $clog2(ENTRIES)
) (
    input logic          clk,
    input logic          rst,
    input logic          cmp_req,
    input logic          match_rst,
    input logic          match_en,
    input logic          full_en,
    input logic          rd_req,
    input logic [1:0]    rd_mode,
    input logic          match_flag,
    input logic [AW-1:0] match_addr,
    input logic [AW-1:0] free_addr,
    input logic          full_flag,
    input logic          rd_valid
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!match_flag && !full_flag && free_addr == '0));

    a_r2_flag_from_compare: assert property (@(posedge clk) disable iff (rst)
        ($rose(match_flag) && $past(match_en)) |-> $past(cmp_req));

    a_r6_hold_addr: assert property (@(posedge clk) disable iff (rst)
        (!$past(cmp_req) && !$past(match_rst)) |-> $stable(match_addr));

    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (match_rst && !cmp_req) |=> (!match_flag && match_addr == '0));

    a_r7_full_no_free: assert property (@(posedge clk) disable iff (rst)
        full_flag |-> free_addr == '0);

    a_r8_match_gate: assert property (@(posedge clk) disable iff (rst)
        !match_en |-> !match_flag);

    a_r8_full_gate: assert property (@(posedge clk) disable iff (rst)
        !full_en |-> !full_flag);

    a_r11_abs_read_valid: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_mode == 2'd0) |=> rd_valid);

    a_r11_no_req_no_valid: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);
endmodule

bind pam_array pam_array_chk #(.ENTRIES(ENTRIES)) u_pam_array_chk (
    .clk        (clk),
    .rst        (rst),
    .cmp_req    (cmp_req),
    .match_rst  (match_rst),
    .match_en   (match_en),
    .full_en    (full_en),
    .rd_req     (rd_req),
    .rd_mode    (rd_mode),
    .match_flag (match_flag),
    .match_addr (match_addr),
    .free_addr  (free_addr),
    .full_flag  (full_flag),
    .rd_valid   (rd_valid)
);

// File: tb/test_pam_array.sv
`timescale 1ns/1ps
module test_pam_array;
    localparam int N  = 16;
    localparam int AW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    split_sel = 2'd3;
    logic          mask_en = 1'b0;
    logic [63:0]   cmp_mask = '0;
    logic          cmp_req = 1'b0, cmp_auto = 1'b0;
    logic [1:0]    cmp_type = 2'b00;
    logic [63:0]   cmp_key = '0;
    logic          match_rst = 1'b0, match_en = 1'b1, full_en = 1'b1;
    logic          wr_req = 1'b0, wr_tag_only = 1'b0;
    logic [1:0]    wr_mode = 2'd0, wr_tag = 2'b00;
    logic [AW-1:0] wr_addr = '0;
    logic [63:0]   wr_data = '0;
    logic          rd_req = 1'b0;
    logic [1:0]    rd_mode = 2'd0;
    logic [AW-1:0] rd_addr = '0;
    logic          match_flag, full_flag, rd_valid;
    logic [AW-1:0] match_addr, free_addr;
    logic [63:0]   rd_data;
    logic [1:0]    rd_tag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pam_array #(.ENTRIES(N)) i_pam_array (.*);

    function automatic logic [63:0] pat(input int i);
        return {16'(16'hA000 + i), 16'(16'hB000 + i), 16'(16'hC000 + i), 16'(16'hD000 + i)};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_write(input logic [1:0] mode, input int addr, input logic [63:0] d,
                            input logic [1:0] tg, input logic tonly);
        wr_req = 1'b1; wr_mode = mode; wr_addr = AW'(addr);
        wr_data = d; wr_tag = tg; wr_tag_only = tonly;
        tick();
        wr_req = 1'b0; wr_tag_only = 1'b0;
    endtask

    task automatic do_cmp(input logic aut, input logic [1:0] typ, input logic [63:0] key);
        cmp_req = 1'b1; cmp_auto = aut; cmp_type = typ; cmp_key = key;
        tick();
        cmp_req = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] mode, input int addr);
        rd_req = 1'b1; rd_mode = mode; rd_addr = AW'(addr);
        tick();
        rd_req = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "match_flag after reset", 64'(match_flag), 64'd0);
        check("R1", "full_flag after reset", 64'(full_flag), 64'd0);
        check("R1", "free_addr after reset", 64'(free_addr), 64'd0);
        do_read(2'd0, 9);
        check("R1", "entry 9 data after reset", rd_data, 64'd0);
        check("R1", "entry 9 tag after reset", 64'(rd_tag), 64'd0);
    endtask

    task automatic t_fill_abs();
        for (int i = 0; i < 4; i++) do_write(2'd0, i, pat(i), 2'b01, 1'b0);
        do_write(2'd0, 5, pat(2), 2'b01, 1'b0);
        check("R7", "free_addr after abs writes", 64'(free_addr), 64'd4);
        do_read(2'd0, 3);
        check("R9", "abs write data", rd_data, pat(3));
        check("R11", "abs read valid", 64'(rd_valid), 64'd1);
    endtask

    task automatic t_priority();
        do_cmp(1'b1, 2'b00, pat(2));
        check("R2", "dup key match flag", 64'(match_flag), 64'd1);
        check("R2", "dup key lowest address", 64'(match_addr), 64'd2);
        do_cmp(1'b1, 2'b00, pat(9));
        check("R2", "absent key flag", 64'(match_flag), 64'd0);
        check("R2", "absent key address", 64'(match_addr), 64'd0);
    endtask

    task automatic t_types();
        do_write(2'd0, 1, 64'd0, 2'b10, 1'b1);
        do_cmp(1'b1, 2'b00, pat(1));
        check("R3", "auto compare skips Skip entry", 64'(match_flag), 64'd0);
        do_cmp(1'b0, 2'b10, pat(1));
        check("R3", "explicit Skip compare flag", 64'(match_flag), 64'd1);
        check("R3", "explicit Skip compare addr", 64'(match_addr), 64'd1);
        do_cmp(1'b0, 2'b11, pat(0));
        check("R3", "RAM compare misses Valid entry", 64'(match_flag), 64'd0);
        do_read(2'd0, 1);
        check("R10", "tag-only write keeps data", rd_data, pat(1));
        check("R11", "read tag of Skip entry", 64'(rd_tag), 64'b10);
    endtask

    task automatic t_split();
        logic [63:0] k;
        k = pat(3) ^ {16'hFFFF, 48'd0};
        split_sel = 2'd3;
        do_cmp(1'b1, 2'b00, k);
        check("R4", "top segment compared with split 3", 64'(match_flag), 64'd0);
        split_sel = 2'd2;
        do_cmp(1'b1, 2'b00, k);
        check("R4", "top segment ignored with split 2 (flag)", 64'(match_flag), 64'd1);
        check("R4", "top segment ignored with split 2 (addr)", 64'(match_addr), 64'd3);
        split_sel = 2'd3;
    endtask

    task automatic t_mask();
        logic [63:0] k;
        k = pat(0) ^ 64'h20;
        mask_en = 1'b0; cmp_mask = 64'h20;
        do_cmp(1'b1, 2'b00, k);
        check("R5", "mask disabled has no effect", 64'(match_flag), 64'd0);
        mask_en = 1'b1;
        do_cmp(1'b1, 2'b00, k);
        check("R5", "masked bit is don't-care (flag)", 64'(match_flag), 64'd1);
        check("R5", "masked bit is don't-care (addr)", 64'(match_addr), 64'd0);
        mask_en = 1'b0; cmp_mask = '0;
    endtask

    task automatic t_hold_and_gate();
        do_cmp(1'b1, 2'b00, pat(3));
        tick(); tick(); tick();
        check("R6", "result held after idle cycles", 64'(match_addr), 64'd3);
        check("R6", "flag held after idle cycles", 64'(match_flag), 64'd1);
        match_en = 1'b0; #1;
        check("R8", "match_en low gates flag", 64'(match_flag), 64'd0);
        match_en = 1'b1; #1;
        check("R8", "match_en restored shows held hit", 64'(match_flag), 64'd1);
        match_rst = 1'b1; tick(); match_rst = 1'b0;
        check("R6", "match_rst clears flag", 64'(match_flag), 64'd0);
        check("R6", "match_rst clears address", 64'(match_addr), 64'd0);
    endtask

    task automatic t_write_match();
        do_cmp(1'b1, 2'b00, pat(2));
        do_write(2'd1, 0, 64'h1234_5678_9ABC_DEF0, 2'b01, 1'b0);
        do_read(2'd0, 2);
        check("R9", "write by match lands on hit", rd_data, 64'h1234_5678_9ABC_DEF0);
        match_rst = 1'b1; tick(); match_rst = 1'b0;
        do_write(2'd1, 0, 64'h5555_5555_5555_5555, 2'b01, 1'b0);
        do_read(2'd0, 0);
        check("R9", "write by match without hit ignored", rd_data, pat(0));
        do_write(2'd3, 0, 64'h6666_6666_6666_6666, 2'b01, 1'b0);
        do_read(2'd0, 0);
        check("R9", "mode 3 write ignored", rd_data, pat(0));
    endtask

    task automatic t_write_free();
        do_write(2'd2, 0, pat(4), 2'b01, 1'b0);
        do_read(2'd0, 4);
        check("R9", "write by free lands on entry 4", rd_data, pat(4));
        check("R7", "free_addr skips used entry 5", 64'(free_addr), 64'd6);
        for (int i = 6; i < N; i++) do_write(2'd2, 0, pat(i), 2'b01, 1'b0);
        check("R7", "full flag when no Empty", 64'(full_flag), 64'd1);
        check("R7", "free_addr zero when full", 64'(free_addr), 64'd0);
        do_write(2'd2, 0, 64'h7777_7777_7777_7777, 2'b01, 1'b0);
        do_read(2'd0, 0);
        check("R9", "write by free when full ignored", rd_data, pat(0));
        full_en = 1'b0; #1;
        check("R8", "full_en low gates flag", 64'(full_flag), 64'd0);
        full_en = 1'b1; #1;
    endtask

    task automatic t_read_modes();
        do_read(2'd2, 0);
        check("R11", "read by free when full not valid", 64'(rd_valid), 64'd0);
        check("R11", "read by free when full keeps tag", 64'(rd_tag), 64'b01);
        do_cmp(1'b0, 2'b10, pat(1));
        do_read(2'd1, 0);
        check("R11", "read by match data", rd_data, pat(1));
        check("R11", "read by match tag", 64'(rd_tag), 64'b10);
        do_write(2'd0, 7, 64'd0, 2'b00, 1'b1);
        check("R7", "full clears after freeing", 64'(full_flag), 64'd0);
        check("R7", "freed entry becomes free_addr", 64'(free_addr), 64'd7);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        tick();
        t_reset();
        t_fill_abs();
        t_priority();
        t_types();
        t_split();
        t_mask();
        t_hold_and_gate();
        t_write_match();
        t_write_free();
        t_read_modes();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule